// File: doc/BRIEF.md
# Competition-Free SPWM Comparator

This block turns one signed modulation value into the two arm gate bits of an H-bridge under unipolar sine-triangle modulation. The left arm compares the modulation value against a bipolar triangle carrier. The right arm compares its negation against the same carrier. The carrier comes from elsewhere. So do its direction bit and a strobe that marks the last cycle of each rising or falling slope. The modulation value may be rewritten on any clock cycle, so a reference that wanders near the carrier could make an arm toggle several times within one slope.

To stop this, each arm holds two lock bits: one for the rising slope and one for the falling slope. The first time an arm's output changes within a slope, the lock for that slope is set. The output then holds until the slope's end strobe clears that lock. The change is applied combinationally in the cycle the comparison flips, so the lockout adds no latency. A narrow-pulse filter, by contrast, must wait out its threshold.

Top module: `spwm_nocomp_cmp`

## Requirements
- R1: While `rst_ni` is low and for the first cycle after it rises, both lock bits of each arm are clear. With modulation and carrier both zero, both arm outputs are 0.
- R2: An arm's wanted level is 1 when its reference is greater than `carrier_i`, compared as two's-complement numbers, and 0 otherwise. When the arm may change, its output takes that level in the same cycle the inputs present it.
- R3: The left reference is `mod_i`. The right reference is `-mod_i`, saturated so that the most negative code maps to the most positive code.
- R4: While `car_rising_i` is 1 (rising slope), an arm output changes at most once until the rising lock is cleared. Later crossings are ignored and the output holds.
- R5: While `car_rising_i` is 0 (falling slope), an arm output changes at most once until the falling lock is cleared.
- R6: `rise_end_i` high in a cycle clears the rising lock of both arms from the next cycle on. `fall_end_i` does the same for the falling lock. A clear takes precedence over a lock set in the same cycle.
- R7: A change on one slope sets only that slope's lock. The opposite slope is still free to change.
- R8: Each arm has its own locks. A change on one arm never blocks the other arm.
- R9: When the wanted level equals the present output, no change happens and no lock is set. This includes the case where the reference equals the carrier while the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | W | Signed triangle carrier sample |
| car_rising_i | input | 1 | 1 on the rising slope, 0 on the falling slope |
| rise_end_i | input | 1 | Last cycle of a rising slope |
| fall_end_i | input | 1 | Last cycle of a falling slope |
| mod_i | input | W | Signed modulation value, may change every cycle |
| pwm_left_o | output | 1 | Left arm gate bit |
| pwm_right_o | output | 1 | Right arm gate bit |

## Verification
The hardest situation to create is a second crossing inside one slope after the lock is set, while the other arm or the other slope remains free. The stimulus first uses directed steps that push the modulation value across the carrier and back within one slope. It then runs several full carrier periods while the modulation value jitters around the carrier every cycle, so that repeated crossings occur on both slopes and both arms. The saturation corner of the right arm is reached by setting the most negative modulation code just below the carrier peak, right after both locks are cleared.

// File: rtl/spwm_cmp_pkg.sv
package spwm_cmp_pkg;
  typedef enum logic {SLOPE_FALL = 1'b0, SLOPE_RISE = 1'b1} slope_e;
  localparam int unsigned ARM_COUNT = 2;
  localparam int unsigned ARM_LEFT  = 0;
  localparam int unsigned ARM_RIGHT = 1;
endpackage

// File: rtl/spwm_ref_split.sv
module spwm_ref_split #(
  parameter int unsigned W = 12
) (
  input  logic signed [W-1:0] mod_i,
  output logic signed [W-1:0] ref_left_o,
  output logic signed [W-1:0] ref_right_o
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  function automatic logic signed [W-1:0] neg_sat(input logic signed [W-1:0] v);
    if (v == MOST_NEG) return MOST_POS;
    return -v;
  endfunction

  assign ref_left_o  = mod_i;
  assign ref_right_o = neg_sat(mod_i);
endmodule

// File: rtl/spwm_arm_lock.sv
module spwm_arm_lock #(
  parameter int unsigned W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic signed [W-1:0] car_i,
  input  logic               rising_i,
  input  logic               rise_end_i,
  input  logic               fall_end_i,
  input  logic signed [W-1:0] ref_i,
  output logic               pwm_o
);
  import spwm_cmp_pkg::*;

  function automatic logic want_level(input logic signed [W-1:0] r,
                                      input logic signed [W-1:0] c);
    return (r > c);
  endfunction

  logic pwm_q, rise_lock_q, fall_lock_q;
  logic want_w, differ_w, lock_sel_w, flip_w;
  slope_e slope_w;

  assign slope_w    = rising_i ? SLOPE_RISE : SLOPE_FALL;
  assign want_w     = want_level(ref_i, car_i);
  assign differ_w   = (want_w != pwm_q);
  assign lock_sel_w = (slope_w == SLOPE_RISE) ? rise_lock_q : fall_lock_q;
  assign flip_w     = differ_w && !lock_sel_w;
  assign pwm_o      = flip_w ? want_w : pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q       <= 1'b0;
      rise_lock_q <= 1'b0;
      fall_lock_q <= 1'b0;
    end else begin
      pwm_q <= pwm_o;
      if (rise_end_i)
        rise_lock_q <= 1'b0;
      else if (flip_w && slope_w == SLOPE_RISE)
        rise_lock_q <= 1'b1;
      if (fall_end_i)
        fall_lock_q <= 1'b0;
      else if (flip_w && slope_w == SLOPE_FALL)
        fall_lock_q <= 1'b1;
    end
  end

  // R4
  one_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rising_i && rise_lock_q) |-> (pwm_o == pwm_q));
  // R5
  one_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rising_i && fall_lock_q) |-> (pwm_o == pwm_q));
  // R6
  rise_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_end_i |=> !rise_lock_q);
  // R6
  fall_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_end_i |=> !fall_lock_q);
  // R7
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o != pwm_q && rising_i && !rise_end_i && !fall_end_i) |=>
      (rise_lock_q && fall_lock_q == $past(fall_lock_q)));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o == pwm_q && !rise_end_i) |=> (rise_lock_q == $past(rise_lock_q)));
endmodule

// File: rtl/spwm_nocomp_cmp.sv
module spwm_nocomp_cmp #(
  parameter int unsigned W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic signed [W-1:0] carrier_i,
  input  logic               car_rising_i,
  input  logic               rise_end_i,
  input  logic               fall_end_i,
  input  logic signed [W-1:0] mod_i,
  output logic               pwm_left_o,
  output logic               pwm_right_o
);
  import spwm_cmp_pkg::*;

  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic signed [W-1:0] ref_w [ARM_COUNT];
  logic [ARM_COUNT-1:0] pwm_w;

  spwm_ref_split #(.W(W)) u_split (
    .mod_i       (mod_i),
    .ref_left_o  (ref_w[ARM_LEFT]),
    .ref_right_o (ref_w[ARM_RIGHT])
  );

  for (genvar a = 0; a < ARM_COUNT; a++) begin : g_arm
    spwm_arm_lock #(.W(W)) u_arm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .car_i      (carrier_i),
      .rising_i   (car_rising_i),
      .rise_end_i (rise_end_i),
      .fall_end_i (fall_end_i),
      .ref_i      (ref_w[a]),
      .pwm_o      (pwm_w[a])
    );
  end

  assign pwm_left_o  = pwm_w[ARM_LEFT];
  assign pwm_right_o = pwm_w[ARM_RIGHT];

  // R3
  ref_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i != MOST_NEG) |-> ((ref_w[ARM_RIGHT] + mod_i) == '0));
  // R3
  ref_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == MOST_NEG) |-> (ref_w[ARM_RIGHT] == MOST_POS));
endmodule

// File: tb/spwm_nocomp_cmp_bench.sv
module spwm_nocomp_cmp_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [W-1:0] car = '0;
  logic signed [W-1:0] md = '0;
  logic rising = 1'b0, re = 1'b0, fe = 1'b0;
  logic pl, pr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  string tag_q[$];
  bit [1:0] exp_q[$];

  bit m_out[2];
  bit m_rl[2];
  bit m_fl[2];

  always #2 clk = ~clk;

  spwm_nocomp_cmp #(.W(W)) u_spwm_nocomp_cmp (
    .clk_i(clk), .rst_ni(rst_n), .carrier_i(car), .car_rising_i(rising),
    .rise_end_i(re), .fall_end_i(fe), .mod_i(md),
    .pwm_left_o(pl), .pwm_right_o(pr)
  );

  function automatic int neg_model(input int v);
    if (v <= -128) return 127;
    return -v;
  endfunction

  task automatic step(input int c, input bit dir, input bit r_end, input bit f_end,
                      input int m, input string tag);
    int refs[2];
    bit exp_v[2];
    @(negedge clk);
    car = 8'(c); md = 8'(m); rising = dir; re = r_end; fe = f_end;
    refs[0] = m;
    refs[1] = neg_model(m);
    for (int a = 0; a < 2; a++) begin
      bit want, locked, nxt;
      want = (refs[a] > c);
      locked = dir ? m_rl[a] : m_fl[a];
      nxt = (rst_n && !locked && want != m_out[a]) ? want : m_out[a];
      exp_v[a] = nxt;
      if (rst_n) begin
        if (nxt != m_out[a]) begin
          if (dir) m_rl[a] = 1'b1; else m_fl[a] = 1'b1;
        end
        m_out[a] = nxt;
        if (r_end) m_rl[a] = 1'b0;
        if (f_end) m_fl[a] = 1'b0;
      end
    end
    tag_q.push_back(tag);
    exp_q.push_back({exp_v[1], exp_v[0]});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if ({pr, pl} !== e) begin
          n_bad++;
          $display("FAIL %s: {right,left} actual=%b expected=%b", t, {pr, pl}, e);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int lfsr;
    int base[3];
    for (int a = 0; a < 2; a++) begin m_out[a] = 0; m_rl[a] = 0; m_fl[a] = 0; end
    // R1: outputs low during reset
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 0, 0, 0, "R1");
    // R2, R3: first crossing on rising slope, both arms
    step(-40, 1, 0, 0, 10, "R2");
    // R4, R8: second crossing ignored on both arms
    step(20, 1, 0, 0, 10, "R4");
    step(30, 1, 1, 0, 50, "R9");
    // R7: falling slope still free
    step(30, 0, 0, 0, 10, "R7");
    // R5: second falling crossing ignored
    step(0, 0, 0, 0, 10, "R5");
    step(-10, 0, 0, 1, -20, "R5");
    // R6: rising lock was cleared by rise_end
    step(-10, 1, 0, 0, -20, "R6");
    step(126, 0, 1, 1, 0, "R6");
    // R3: saturation of most negative code
    step(126, 1, 0, 0, -128, "R3");
    // R9: reference equal to carrier while output low
    step(40, 1, 1, 1, -40, "R9");
    step(40, 1, 0, 0, 40, "R9");
    // R8, R4, R5: carrier periods with jittering modulation
    lfsr = 32'h1ACE;
    base[0] = -30; base[1] = 45; base[2] = 0;
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 50; k++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        step(-100 + 4 * k, 1, k == 49, 0, base[p] + (lfsr & 15) - 8, "R8");
      end
      for (int k = 0; k < 50; k++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        step(100 - 4 * k, 0, 0, k == 49, base[p] + (lfsr & 15) - 8, "R8");
      end
    end
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule